// File: doc/BRIEF.md
# Serial Management Register Responder

This block sits on the PHY side of a two-wire management bus. It watches a management clock and a data line, both driven by a station manager, and oversamples them with its own system clock. On each rising edge of the management clock it takes in one bit. A data bit counts as 1 only while the manager both drives the line high and has its output enable asserted. A run of 32 or more ones arms a frame counter. The next sixteen bits are taken as a header that holds a start code, an opcode, a PHY address, a register index and a turnaround code.

A valid read header loads one entry of an internal bank of 32 sixteen-bit registers. That entry is then shifted onto the read-data output, most significant bit first, one bit per following management-clock rising edge. A valid write header makes the block collect the next sixteen bits and, when the parameter `STORE_WR` is set, store them at the addressed entry. Any other header drops the frame. The PHY address is not compared, so the block answers on every address. Registers 2 and 3 come out of reset holding the identifier values 0x0022 and 0x161A. Every other register resets to zero.

Top module: `mdio_resp`

## Requirements
- R1: A sampled bit is 1 only when data-out and output-enable are both high at a management-clock rising edge, so a run of ones sent with output-enable low does not arm a frame.
- R2: A frame is armed only once 32 consecutive sampled ones have been seen. A run of 31 ones followed by a header gives no response. A preamble longer than 32 ones still works.
- R3: The 16 bits after the preamble are decoded MSB first as start[15:14], opcode[13:12], PHY address[11:7], register index[6:2] and turnaround[1:0]. A read needs start 01 and opcode 10.
- R4: For a read, only turnaround bit 0 is checked and it must be 0. Turnaround 00 and 10 are accepted. Turnaround 01 and 11 abort the frame.
- R5: On a read, the addressed register is driven out MSB first. Each bit appears on one of the 16 rising edges that follow the header, and the output holds between edges.
- R6: A write needs start 01, opcode 01 and turnaround exactly 10. With STORE_WR=1, the 16 bits that follow are stored at the register index, and a later read returns them.
- R7: After reset, register 2 reads 0x0022, register 3 reads 0x161A and every other register reads 0x0000.
- R8: The read-data output is 0 after reset and after any rising edge that does not shift out a read bit, which includes the whole of a write frame.
- R9: The PHY address field has no effect on which register is accessed or whether the block answers.
- R10: A header with a start code other than 01 or an opcode other than 01/10 gives no output and stores nothing. A write with a bad turnaround also leaves the register bank unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low synchronous reset |
| mdc | input | 1 | Management clock from the station manager |
| mdo | input | 1 | Data driven by the station manager |
| moe | input | 1 | Station manager output enable |
| mdi | output | 1 | Serial read data back to the station manager |

## Verification
The hardest condition to reach is the boundary of the preamble detector. The 32-bit history must hold exactly 31 ones and then break, or it must keep being refilled by a preamble longer than 32 bits. In both cases the counter must not be left half-armed by an earlier frame. The stimulus reaches this in two steps. It first clears the history with zero bits, then drives a 31-one run followed by a well-formed read header and expects silence. A 40-one preamble follows, which must still line the header up correctly. A second hard case is a write that is rejected only by its turnaround code. It is exposed by reading the same register back afterwards.

// File: rtl/mdio_resp.sv
module mdio_resp #(
  parameter bit          STORE_WR = 1'b1,
  parameter logic [15:0] ID_HI    = 16'h0022,
  parameter logic [15:0] ID_LO    = 16'h161A,
  parameter int          PRE_LEN  = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mdc,
  input  logic mdo,
  input  logic moe,
  output logic mdi
);
  localparam int AW    = 5;
  localparam int NREG  = 1 << AW;
  localparam int DW    = 16;
  localparam int CW    = $clog2(PRE_LEN + 1);
  localparam logic [CW-1:0] C_LOAD = CW'(PRE_LEN);
  localparam logic [CW-1:0] C_HDR  = CW'(DW);
  localparam logic [1:0] ST_IDLE = 2'd0;
  localparam logic [1:0] ST_RD   = 2'd1;
  localparam logic [1:0] ST_WR   = 2'd2;

  logic mdc_s1, mdc_s2, mdo_s1, moe_s1;
  logic [PRE_LEN-2:0] hist;
  logic [CW-1:0] cnt;
  logic active;
  logic [1:0] st, st_n;
  logic [AW-1:0] addr;
  logic [DW-1:0] dout;
  logic [DW-1:0] bank [NREG];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mdc_s1 <= 1'b0; mdc_s2 <= 1'b0; mdo_s1 <= 1'b0; moe_s1 <= 1'b0;
    end else begin
      mdc_s1 <= mdc; mdc_s2 <= mdc_s1; mdo_s1 <= mdo; moe_s1 <= moe;
    end
  end

  wire               rise   = mdc_s1 & ~mdc_s2;
  wire               din    = mdo_s1 & moe_s1;
  wire [PRE_LEN-1:0] hist_n = {hist, din};
  wire               sync   = &hist_n;
  wire               act_c  = sync | active;
  wire [CW-1:0]      c      = sync ? C_LOAD : cnt;
  wire               hdr    = act_c && (c == C_HDR);
  wire               is_wr  = hist_n[15:14] == 2'b01 && hist_n[13:12] == 2'b01 && hist_n[1:0] == 2'b10;
  wire               is_rd  = hist_n[15:14] == 2'b01 && hist_n[13:12] == 2'b10 && !hist_n[0];
  wire [AW-1:0]      reg_f  = hist_n[6:2];

  always_comb begin
    st_n = st;
    if (hdr) st_n = is_wr ? ST_WR : (is_rd ? ST_RD : ST_IDLE);
  end

  wire shift = act_c && (c < C_HDR) && (st_n == ST_RD);
  wire fin   = act_c && (c == '0) && (st_n != ST_IDLE);
  wire we    = STORE_WR && rise && fin && (st_n == ST_WR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hist   <= '0;
      cnt    <= '0;
      active <= 1'b0;
      st     <= ST_IDLE;
      addr   <= '0;
      dout   <= '0;
      mdi    <= 1'b0;
    end else if (rise) begin
      hist <= hist_n[PRE_LEN-2:0];
      st   <= fin ? ST_IDLE : st_n;
      if (act_c) begin
        if (c == '0) active <= 1'b0;
        else begin
          active <= 1'b1;
          cnt    <= c - CW'(1);
        end
      end
      if (hdr && st_n != ST_IDLE) addr <= reg_f;
      if (hdr && is_rd) dout <= bank[reg_f];
      else if (shift)   dout <= {dout[DW-2:0], 1'b0};
      mdi <= shift ? dout[DW-1] : 1'b0;
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : g_bank
    localparam logic [DW-1:0] RV = (g == 2) ? ID_HI : ((g == 3) ? ID_LO : '0);
    always_ff @(posedge clk) begin
      if (!rst_n) bank[g] <= RV;
      else if (we && addr == AW'(g)) bank[g] <= hist_n[DW-1:0];
    end
  end
endmodule

// File: rtl/mdio_resp_chk.sv
module mdio_resp_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        rise,
  input logic        mdi,
  input logic [31:0] hist_n,
  input logic        active,
  input logic [5:0]  cnt,
  input logic [1:0]  st
);
  a_r2_sync_loads: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && (&hist_n)) |=> (active && cnt == 6'd31));

  a_r5_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
    !rise |=> $stable(mdi));

  a_r8_quiet_unless_read: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && st != 2'd1) |=> !mdi);

  a_r3_read_in_low_half: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd1) |-> (active && cnt < 6'd16));

  a_r6_write_in_low_half: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd2) |-> (active && cnt < 6'd16));

  a_r10_idle_when_unarmed: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> (st == 2'd0));
endmodule

bind mdio_resp mdio_resp_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rise(rise), .mdi(mdi),
  .hist_n(hist_n), .active(active), .cnt(cnt), .st(st)
);

// File: tb/mdio_resp_bench.sv
module mdio_resp_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mdc = 1'b0, mdo = 1'b0, moe = 1'b0;
  logic mdi;
  int   n_chk = 0, n_fail = 0;
  bit   done = 1'b0;
  bit   exp_q[$];
  string tag_q[$];
  logic [15:0] model [32];
  event smp;

  always #10 clk = ~clk;

  mdio_resp u_mdio_resp (.clk(clk), .rst_n(rst_n), .mdc(mdc), .mdo(mdo), .moe(moe), .mdi(mdi));

  initial begin
    forever begin
      @(smp);
      if (exp_q.size() != 0) begin
        automatic bit e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        n_chk++;
        if (mdi !== e) begin
          n_fail++;
          $display("FAIL %s: mdi actual %0b expected %0b", t, mdi, e);
        end
      end
    end
  end

  task automatic tick(input bit b, input bit oe, input bit e, input string t);
    @(negedge clk);
    mdo = b; moe = oe; mdc = 1'b0;
    exp_q.push_back(e); tag_q.push_back(t);
    repeat (3) @(negedge clk);
    mdc = 1'b1;
    repeat (4) @(negedge clk);
    ->smp;
    #1;
  endtask

  task automatic frame(input int pn, input bit p_oe, input logic [1:0] st2, input logic [1:0] op2,
                       input logic [4:0] phy, input logic [4:0] rg, input logic [1:0] ta,
                       input bit ta_oe, input logic [15:0] dat, input bit d_oe,
                       input bit rd_ok, input logic [15:0] ev, input string t);
    logic [15:0] h;
    h = {st2, op2, phy, rg, ta};
    for (int i = 0; i < pn; i++) tick(1'b1, p_oe, 1'b0, t);
    for (int i = 15; i >= 2; i--) tick(h[i], 1'b1, 1'b0, t);
    for (int i = 1; i >= 0; i--) tick(h[i], ta_oe, 1'b0, t);
    for (int i = 15; i >= 0; i--) tick(dat[i], d_oe, rd_ok ? ev[i] : 1'b0, t);
    tick(1'b0, 1'b0, 1'b0, t);
  endtask

  task automatic rd(input logic [4:0] phy, input logic [4:0] rg, input string t);
    frame(32, 1'b1, 2'b01, 2'b10, phy, rg, 2'b00, 1'b0, 16'hFFFF, 1'b0, 1'b1, model[rg], t);
  endtask

  task automatic wr(input logic [4:0] phy, input logic [4:0] rg, input logic [15:0] d, input string t);
    frame(32, 1'b1, 2'b01, 2'b01, phy, rg, 2'b10, 1'b1, d, 1'b1, 1'b0, 16'h0, t);
    model[rg] = d;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R5 watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 32; i++) model[i] = 16'h0;
    model[2] = 16'h0022; model[3] = 16'h161A;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    n_chk++;
    if (mdi !== 1'b0) begin n_fail++; $display("FAIL R8: reset mdi actual %0b expected 0", mdi); end

    rd(5'd0, 5'd2, "R7");
    rd(5'd0, 5'd3, "R7");
    rd(5'd1, 5'd0, "R7");
    rd(5'd0, 5'd31, "R7");
    wr(5'd0, 5'd5, 16'hA5C3, "R6");
    rd(5'd9, 5'd5, "R9");
    wr(5'd3, 5'd0, 16'h8001, "R6");
    rd(5'd17, 5'd0, "R5");
    wr(5'd31, 5'd31, 16'hFFFF, "R8");
    rd(5'd4, 5'd31, "R3");
    frame(32, 1'b1, 2'b01, 2'b10, 5'd0, 5'd5, 2'b10, 1'b1, 16'hFFFF, 1'b0, 1'b1, model[5], "R4");
    frame(32, 1'b1, 2'b01, 2'b10, 5'd0, 5'd5, 2'b01, 1'b1, 16'hFFFF, 1'b0, 1'b0, 16'h0, "R4");
    frame(32, 1'b1, 2'b01, 2'b10, 5'd0, 5'd3, 2'b11, 1'b1, 16'hFFFF, 1'b0, 1'b0, 16'h0, "R4");
    frame(32, 1'b1, 2'b01, 2'b11, 5'd0, 5'd3, 2'b10, 1'b1, 16'hFFFF, 1'b0, 1'b0, 16'h0, "R10");
    frame(32, 1'b1, 2'b00, 2'b10, 5'd0, 5'd3, 2'b00, 1'b0, 16'hFFFF, 1'b0, 1'b0, 16'h0, "R10");
    frame(32, 1'b1, 2'b01, 2'b01, 5'd0, 5'd5, 2'b11, 1'b1, 16'h1234, 1'b1, 1'b0, 16'h0, "R10");
    rd(5'd0, 5'd5, "R10");
    for (int i = 0; i < 8; i++) tick(1'b0, 1'b1, 1'b0, "R2");
    frame(31, 1'b1, 2'b01, 2'b10, 5'd0, 5'd2, 2'b00, 1'b0, 16'hFFFF, 1'b0, 1'b0, 16'h0, "R2");
    frame(40, 1'b1, 2'b01, 2'b10, 5'd0, 5'd3, 2'b00, 1'b0, 16'hFFFF, 1'b0, 1'b1, model[3], "R2");
    frame(32, 1'b0, 2'b01, 2'b10, 5'd0, 5'd2, 2'b00, 1'b0, 16'hFFFF, 1'b0, 1'b0, 16'h0, "R1");
    rd(5'd0, 5'd2, "R1");

    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule